// File: doc/BRIEF.md
# Prefix-Length Ordered Route Lookup

This block resolves an IPv4 longest-prefix-match route for a given virtual router. Routes are grouped by prefix length. Each length has its own small exact-match table, and every entry in a table carries that table's length. A lookup checks the longest-length table first. On a miss it falls back to the next shorter table, one table per clock cycle, and it stops at the first table that hits. A route that is found closer to the short end of the list therefore costs more cycles.

A request carries a virtual router id and a destination address. While the walk runs, the block keeps a prefix-length tag with the request. A table can answer only when the tag equals that table's own length. A hit returns:
- the adjacency index,
- the adjacency group size,
- the egress router-interface id,
- a flag that sends the packet to the local-host path instead of the adjacency path.

A request that no table answers, including the zero-length default table, produces a miss with every result field at zero. Each table has a saturating hit counter, and the management side can select and read any of them. The management side also writes route entries into any slot of any table. Both the request side and the result side use a valid/ready handshake. The block takes a new request only when it is idle.

Top module: `lpm_route_lookup`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` is 0 and every hit counter reads 0.
- R2: A table entry matches when three conditions hold: it is valid, its virtual router id equals the request's exactly, and its prefix equals the destination address after both are masked to the table's prefix length. Bits below the prefix length do not matter, in the request or in the stored prefix.
- R3: The walk starts at table 0, which holds the longest length. When several tables hold a matching route, the longest one is returned.
- R4: Table index i holds length 32 − 8·i, so the defaults are /32, /24, /16, /8 and /0 at indices 0 to 4. A hit in table i raises `res_valid` exactly i+1 cycles after the accepting edge. A full miss raises it after 5 cycles.
- R5: A hit sets `res_hit` to 1 and returns the stored adjacency index, group size, egress interface and local flag of the matching entry.
- R6: When no table hits, `res_hit` is 0 and `res_local`, `res_adj_idx`, `res_grp_size` and `res_rif` are all 0.
- R7: `req_ready` is 1 only while idle. While `res_valid` is 1 and `res_ready` is 0, the result stays valid and unchanged.
- R8: When several slots of one table match, the lowest slot number wins.
- R9: A table's hit counter, selected by `cnt_sel` = table index, rises by one for each lookup that hits in that table. It saturates at 255.
- R10: A management write with `cfg_we`=1 replaces slot `cfg_slot` of table `cfg_tbl`. Writing `cfg_valid`=0 removes the route.
- R11: The /0 table matches any address within its virtual router and serves as the default route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_vrid | input | 4 | Virtual router id of the request |
| req_dst | input | 32 | IPv4 destination address |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | 1 = route found, 0 = miss |
| res_local | output | 1 | Directly connected route, next stage is the local-host path |
| res_adj_idx | output | 12 | Adjacency index |
| res_grp_size | output | 4 | Adjacency group size |
| res_rif | output | 6 | Egress router-interface id |
| cfg_we | input | 1 | Entry write strobe |
| cfg_tbl | input | 3 | Table index to write |
| cfg_slot | input | 2 | Slot within the table |
| cfg_valid | input | 1 | Entry valid bit to write |
| cfg_vrid | input | 4 | Entry virtual router id |
| cfg_prefix | input | 32 | Entry prefix (bits below the length ignored) |
| cfg_local | input | 1 | Entry local-route flag |
| cfg_adj_idx | input | 12 | Entry adjacency index |
| cfg_grp_size | input | 4 | Entry adjacency group size |
| cfg_rif | input | 6 | Entry egress interface id |
| cnt_sel | input | 3 | Hit counter select (table index) |
| cnt_val | output | 8 | Selected hit counter value |

## Verification
The bench targets four kinds of mistake:
- Overlapping routes in /32, /24 and /16. A walk that starts at the wrong end, or that does not stop at the first hit, returns a shorter route.
- Host bits set in both the address and the stored prefix. A masking error turns these into misses or wrong-table hits.
- A /8 route that belongs to a different virtual router. A design that ignores the router id takes it instead of the default route.
- Duplicate matches inside one table, deleted slots, and held-back results. These expose wrong slot priority, stale entries, and outputs that change under backpressure.

Each result's latency is measured against its table index, which exposes a skipped or repeated table. More than 255 default-route hits check that the counter clamps and does not wrap.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    parameter int VRID_W = 4;
    parameter int ADDR_W = 32;
    parameter int ADJ_W  = 12;
    parameter int GSZ_W  = 4;
    parameter int RIF_W  = 6;
    localparam int TAG_W = $clog2(ADDR_W + 1);

    typedef struct packed {
        logic [VRID_W-1:0] vrid;
        logic [ADDR_W-1:0] dst;
    } lkp_key_t;

    typedef struct packed {
        logic             hit;
        logic             local_rt;
        logic [ADJ_W-1:0] adj_idx;
        logic [GSZ_W-1:0] grp_size;
        logic [RIF_W-1:0] rif;
    } lkp_res_t;

    typedef struct packed {
        logic              valid;
        logic [VRID_W-1:0] vrid;
        logic [ADDR_W-1:0] prefix;
        logic              local_rt;
        logic [ADJ_W-1:0]  adj_idx;
        logic [GSZ_W-1:0]  grp_size;
        logic [RIF_W-1:0]  rif;
    } route_ent_t;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_WALK = 2'd1,
        WK_DONE = 2'd2
    } walk_st_t;

    // prefix length checked at a walk stage
    function automatic int unsigned stage_len(input int unsigned idx, input int unsigned step);
        return ADDR_W - idx * step;
    endfunction

    // mask with the top len bits set
    function automatic logic [ADDR_W-1:0] pfx_mask(input int unsigned len);
        logic [ADDR_W-1:0] m;
        m = '0;
        for (int b = 0; b < ADDR_W; b++) begin
            if (b + int'(len) >= ADDR_W) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/lpm_hit_counter.sv
module lpm_hit_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

    // R9: clamps at the top value
    a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_MAX) |=> (count == CNT_MAX));
    // R9: one step per hit below the top
    a_r9_step: assert property (@(posedge clk) disable iff (rst)
        (inc && count != CNT_MAX) |=> (count == $past(count) + 1'b1));
    // R9: no change without a hit
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(count));
endmodule

// File: rtl/lpm_table.sv
module lpm_table
    import lpm_pkg::*;
#(
    parameter int          SLOTS  = 4,
    parameter int unsigned MY_LEN = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  route_ent_t        wr_ent,
    input  lkp_key_t          key,
    input  logic [TAG_W-1:0]  tag,
    output lkp_res_t          res
);
    localparam logic [ADDR_W-1:0] MASK   = pfx_mask(MY_LEN);
    localparam logic [TAG_W-1:0]  MY_TAG = TAG_W'(MY_LEN);

    route_ent_t       mem [SLOTS];
    logic [SLOTS-1:0] slot_hit;
    logic             tag_ok;
    route_ent_t       pick;
    logic             any_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SLOTS; s++) mem[s] <= '0;
        end else if (wr_en) begin
            mem[wr_slot] <= wr_ent;
        end
    end

    assign tag_ok = (tag == MY_TAG);

    for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
        assign slot_hit[s] = tag_ok && mem[s].valid &&
                             (mem[s].vrid == key.vrid) &&
                             (((mem[s].prefix ^ key.dst) & MASK) == '0);
    end

    // lowest slot wins
    always_comb begin
        any_hit = 1'b0;
        pick    = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (slot_hit[s]) begin
                any_hit = 1'b1;
                pick    = mem[s];
            end
        end
    end

    always_comb begin
        res = '0;
        if (any_hit) begin
            res.hit      = 1'b1;
            res.local_rt = pick.local_rt;
            res.adj_idx  = pick.adj_idx;
            res.grp_size = pick.grp_size;
            res.rif      = pick.rif;
        end
    end

    // R10: a written entry lands in its slot
    a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_slot)] == $past(wr_ent)));
    // R2: a hit needs the tag of this table
    a_r2_tag_gate: assert property (@(posedge clk) disable iff (rst)
        res.hit |-> (tag == MY_TAG));
endmodule

// File: rtl/lpm_walker.sv
module lpm_walker
    import lpm_pkg::*;
#(
    parameter int NUM_TBL  = 5,
    parameter int LEN_STEP = 8,
    localparam int TBL_W = $clog2(NUM_TBL)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  lkp_key_t              req_key,
    output lkp_key_t              key_o,
    output logic [TAG_W-1:0]      tag_o,
    input  lkp_res_t [NUM_TBL-1:0] tbl_res,
    output logic [NUM_TBL-1:0]    hit_pulse,
    output logic                  res_valid,
    input  logic                  res_ready,
    output lkp_res_t              res_o
);
    localparam logic [TBL_W-1:0] LAST = TBL_W'(NUM_TBL - 1);

    walk_st_t         st;
    logic [TBL_W-1:0] stage;
    lkp_key_t         key_q;
    lkp_res_t         res_q;
    lkp_res_t         cur;

    assign cur = tbl_res[stage];

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= WK_IDLE;
            stage <= '0;
            key_q <= '0;
            res_q <= '0;
        end else begin
            unique case (st)
                WK_IDLE: begin
                    if (req_valid) begin
                        key_q <= req_key;
                        stage <= '0;
                        st    <= WK_WALK;
                    end
                end
                WK_WALK: begin
                    if (cur.hit) begin
                        res_q <= cur;
                        st    <= WK_DONE;
                    end else if (stage == LAST) begin
                        res_q <= '0;
                        st    <= WK_DONE;
                    end else begin
                        stage <= stage + 1'b1;
                    end
                end
                WK_DONE: begin
                    if (res_ready) st <= WK_IDLE;
                end
                default: st <= WK_IDLE;
            endcase
        end
    end

    always_comb begin
        hit_pulse = '0;
        if (st == WK_WALK && cur.hit) hit_pulse[stage] = 1'b1;
    end

    assign key_o     = key_q;
    assign tag_o     = TAG_W'(stage_len(32'(stage), LEN_STEP));
    assign req_ready = (st == WK_IDLE);
    assign res_valid = (st == WK_DONE);
    assign res_o     = res_q;

    // R7: result held under backpressure
    a_r7_hold_result: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_o)));
    // R7: never ready while a result waits
    a_r7_ready_idle: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !req_ready);
    // R6: a miss carries zero fields
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_o.hit) |-> (res_o == '0));
    // R3: every walk begins at the longest table
    a_r3_start_long: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (stage == '0));
    // R4: one table per cycle
    a_r4_one_step: assert property (@(posedge clk) disable iff (rst)
        (st == WK_WALK && !cur.hit && stage != LAST) |=> (stage == $past(stage) + 1'b1));
endmodule

// File: rtl/lpm_route_lookup.sv
module lpm_route_lookup
    import lpm_pkg::*;
#(
    parameter int LEN_STEP = 8,
    parameter int SLOTS    = 4,
    parameter int CNT_W    = 8,
    localparam int NUM_TBL = ADDR_W / LEN_STEP + 1,
    localparam int TBL_W   = $clog2(NUM_TBL),
    localparam int SLOT_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VRID_W-1:0] req_vrid,
    input  logic [ADDR_W-1:0] req_dst,
    output logic              res_valid,
    input  logic              res_ready,
    output logic              res_hit,
    output logic              res_local,
    output logic [ADJ_W-1:0]  res_adj_idx,
    output logic [GSZ_W-1:0]  res_grp_size,
    output logic [RIF_W-1:0]  res_rif,
    input  logic              cfg_we,
    input  logic [TBL_W-1:0]  cfg_tbl,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic              cfg_valid,
    input  logic [VRID_W-1:0] cfg_vrid,
    input  logic [ADDR_W-1:0] cfg_prefix,
    input  logic              cfg_local,
    input  logic [ADJ_W-1:0]  cfg_adj_idx,
    input  logic [GSZ_W-1:0]  cfg_grp_size,
    input  logic [RIF_W-1:0]  cfg_rif,
    input  logic [TBL_W-1:0]  cnt_sel,
    output logic [CNT_W-1:0]  cnt_val
);
    lkp_key_t              req_key;
    lkp_key_t              walk_key;
    logic [TAG_W-1:0]      walk_tag;
    lkp_res_t [NUM_TBL-1:0] tbl_res;
    logic [NUM_TBL-1:0]    tbl_hit;
    logic [NUM_TBL-1:0]    hit_pulse;
    logic [CNT_W-1:0]      cnt_arr [NUM_TBL];
    route_ent_t            cfg_ent;
    lkp_res_t              res;

    assign req_key = '{vrid: req_vrid, dst: req_dst};

    always_comb begin
        cfg_ent          = '0;
        cfg_ent.valid    = cfg_valid;
        cfg_ent.vrid     = cfg_vrid;
        cfg_ent.prefix   = cfg_prefix;
        cfg_ent.local_rt = cfg_local;
        cfg_ent.adj_idx  = cfg_adj_idx;
        cfg_ent.grp_size = cfg_grp_size;
        cfg_ent.rif      = cfg_rif;
    end

    for (genvar i = 0; i < NUM_TBL; i++) begin : g_tbl
        lpm_table #(
            .SLOTS (SLOTS),
            .MY_LEN(stage_len(i, LEN_STEP))
        ) u_tbl (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (cfg_we && (cfg_tbl == TBL_W'(i))),
            .wr_slot(cfg_slot),
            .wr_ent (cfg_ent),
            .key    (walk_key),
            .tag    (walk_tag),
            .res    (tbl_res[i])
        );

        lpm_hit_counter #(
            .CNT_W(CNT_W)
        ) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .inc  (hit_pulse[i]),
            .count(cnt_arr[i])
        );

        assign tbl_hit[i] = tbl_res[i].hit;
    end

    lpm_walker #(
        .NUM_TBL (NUM_TBL),
        .LEN_STEP(LEN_STEP)
    ) u_walk (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_key  (req_key),
        .key_o    (walk_key),
        .tag_o    (walk_tag),
        .tbl_res  (tbl_res),
        .hit_pulse(hit_pulse),
        .res_valid(res_valid),
        .res_ready(res_ready),
        .res_o    (res)
    );

    assign res_hit      = res.hit;
    assign res_local    = res.local_rt;
    assign res_adj_idx  = res.adj_idx;
    assign res_grp_size = res.grp_size;
    assign res_rif      = res.rif;

    assign cnt_val = (int'(cnt_sel) < NUM_TBL) ? cnt_arr[cnt_sel] : '0;

    // R3: the tag lets at most one table answer
    a_r3_single_table: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tbl_hit));
    // R9: at most one counter moves per cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        $countones(hit_pulse) <= 1);
endmodule

// File: tb/lpm_route_lookup_test.sv
module lpm_route_lookup_test;
    import lpm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_vrid = '0;
    logic [31:0] req_dst = '0;
    logic        res_valid;
    logic        res_ready = 1'b1;
    logic        res_hit, res_local;
    logic [11:0] res_adj_idx;
    logic [3:0]  res_grp_size;
    logic [5:0]  res_rif;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_tbl = '0;
    logic [1:0]  cfg_slot = '0;
    logic        cfg_valid = 1'b0;
    logic [3:0]  cfg_vrid = '0;
    logic [31:0] cfg_prefix = '0;
    logic        cfg_local = 1'b0;
    logic [11:0] cfg_adj_idx = '0;
    logic [3:0]  cfg_grp_size = '0;
    logic [5:0]  cfg_rif = '0;
    logic [2:0]  cnt_sel = '0;
    logic [7:0]  cnt_val;

    lpm_route_lookup uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vrid(req_vrid), .req_dst(req_dst),
        .res_valid(res_valid), .res_ready(res_ready),
        .res_hit(res_hit), .res_local(res_local),
        .res_adj_idx(res_adj_idx), .res_grp_size(res_grp_size), .res_rif(res_rif),
        .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_slot(cfg_slot),
        .cfg_valid(cfg_valid), .cfg_vrid(cfg_vrid), .cfg_prefix(cfg_prefix),
        .cfg_local(cfg_local), .cfg_adj_idx(cfg_adj_idx),
        .cfg_grp_size(cfg_grp_size), .cfg_rif(cfg_rif),
        .cnt_sel(cnt_sel), .cnt_val(cnt_val)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        bit    hit;
        bit    loc;
        int    adj;
        int    gsz;
        int    rif;
        int    lat;
        int    acc;
        string rq;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    int   hits_model[NT];
    bit   seen = 0;
    int   t_first = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (!rst) begin
            if (res_valid && !seen) begin
                seen    = 1;
                t_first = cyc;
            end
            if (res_valid && res_ready) begin
                if (q.size() == 0) begin
                    chk("R7", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.rq, "hit", res_hit, e.hit);
                    chk(e.rq, "local", res_local, e.loc);
                    chk(e.rq, "adj_idx", res_adj_idx, e.adj);
                    chk(e.rq, "grp_size", res_grp_size, e.gsz);
                    chk(e.rq, "rif", res_rif, e.rif);
                    chk("R4", {e.rq, " latency"}, t_first - e.acc, e.lat);
                end
                seen = 0;
            end
        end
    end

    task automatic wr(input int tbl, input int slot, input bit v, input int vr,
                      input logic [31:0] pfx, input bit loc, input int adj,
                      input int gsz, input int rif);
        @(negedge clk);
        cfg_we = 1; cfg_tbl = 3'(tbl); cfg_slot = 2'(slot); cfg_valid = v;
        cfg_vrid = 4'(vr); cfg_prefix = pfx; cfg_local = loc;
        cfg_adj_idx = 12'(adj); cfg_grp_size = 4'(gsz); cfg_rif = 6'(rif);
        @(negedge clk);
        cfg_we = 0;
    endtask

    // tbl < 0 means a full miss
    task automatic lookup(input int vr, input logic [31:0] a, input int tbl,
                          input bit loc, input int adj, input int gsz,
                          input int rif, input string rq);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_vrid = 4'(vr); req_dst = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        e.hit = (tbl >= 0);
        e.loc = loc; e.adj = adj; e.gsz = gsz; e.rif = rif;
        e.lat = (tbl >= 0) ? tbl + 1 : NT;
        e.acc = cyc;
        e.rq  = rq;
        q.push_back(e);
        if (tbl >= 0) hits_model[tbl]++;
    endtask

    task automatic drain();
        @(negedge clk);
        while (q.size() != 0 || !req_ready) @(negedge clk);
    endtask

    task automatic chk_cnt(input int tbl, input string rq);
        @(negedge clk);
        cnt_sel = 3'(tbl);
        #1;
        chk(rq, $sformatf("counter t%0d", tbl), cnt_val,
            (hits_model[tbl] > 255) ? 255 : hits_model[tbl]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NT; i++) hits_model[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "req_ready", req_ready, 1);
        chk("R1", "res_valid", res_valid, 0);
        for (int i = 0; i < NT; i++) chk_cnt(i, "R1");

        // route set: t0=/32 t1=/24 t2=/16 t3=/8 t4=/0
        wr(0, 0, 1, 1, 32'h0A010203, 1, 11, 1, 3);
        wr(1, 0, 1, 1, 32'h0A010200, 0, 22, 2, 4);
        wr(2, 2, 1, 1, 32'h0A010000, 0, 33, 4, 5);
        wr(3, 0, 1, 2, 32'h0A000000, 0, 44, 2, 6);
        wr(4, 1, 1, 1, 32'h00000000, 0, 55, 3, 7);

        lookup(1, 32'h0A010203, 0, 1, 11, 1, 3, "R3 /32 wins");
        lookup(1, 32'h0A010209, 1, 0, 22, 2, 4, "R2 /24 host bits");
        lookup(1, 32'h0A010707, 2, 0, 33, 4, 5, "R5 /16 fields");
        lookup(2, 32'h0A090909, 3, 0, 44, 2, 6, "R2 /8 vrid");
        lookup(1, 32'h0A090909, 4, 0, 55, 3, 7, "R11 default");
        lookup(3, 32'h01020304, -1, 0, 0, 0, 0, "R6 miss");
        drain();

        // R8 lowest slot, R10 removal / overwrite
        wr(1, 2, 1, 1, 32'h0A0102C8, 0, 77, 1, 9);
        lookup(1, 32'h0A010209, 1, 0, 22, 2, 4, "R8 low slot");
        drain();
        wr(1, 0, 0, 1, 32'h0A010200, 0, 22, 2, 4);
        lookup(1, 32'h0A010209, 1, 0, 77, 1, 9, "R10 removed slot");
        drain();
        wr(0, 0, 1, 1, 32'h0A010203, 0, 12, 2, 8);
        lookup(1, 32'h0A010203, 0, 0, 12, 2, 8, "R10 overwrite");
        drain();

        // R7 backpressure
        res_ready = 0;
        lookup(1, 32'h0A010707, 2, 0, 33, 4, 5, "R7 held");
        repeat (6) @(negedge clk);
        chk("R7", "res_valid held", res_valid, 1);
        chk("R7", "req_ready busy", req_ready, 0);
        chk("R7", "adj stable", res_adj_idx, 33);
        res_ready = 1;
        drain();

        // R9 counters
        chk_cnt(0, "R9");
        chk_cnt(3, "R9");
        chk_cnt(1, "R9");
        for (int k = 0; k < 260; k++)
            lookup(1, 32'hC8000001 + k, 4, 0, 55, 3, 7, "R11 loop");
        drain();
        chk_cnt(4, "R9 saturate");
        chk_cnt(2, "R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule